// File: doc/BRIEF.md
# PCI Bridge Configuration Cycle Translator

This block sits on the downstream side of a virtual host-to-PCI bridge, behind the host's configuration address register. Each configuration request arrives as separate bus, device, function and register fields plus a read/write flag. The block compares the bus number with the bridge's secondary and subordinate bus numbers and chooses one of three outcomes. A request for the secondary bus becomes a Type 0 cycle, with a one-hot device select on the upper address lines. A request for a bus further down the hierarchy becomes a Type 1 cycle. Any other request is not forwarded.

The translated address, the cycle kind and the write flag are registered. They are presented with a valid strobe and held until the downstream side takes them. A request that is not forwarded still yields a result, tagged "no cycle", so the host side can return all-ones on a read and drop a write. The two bus-number registers are loaded through a small write port.

Top module: `cfg_cycle_xlate`

## Requirements
- R1: After reset, `dn_valid` is 0, `req_ready` is 1, and both bus-number registers hold 0.
- R2: A request whose bus number equals the secondary bus number yields kind code 2'b01 (Type 0). When secondary is 0, bus 0 matches.
- R3: For Type 0 with device number n in 0..15, address bits [31:16] are one-hot with bit 16+n set.
- R4: For Type 0 with device number 16..31 (top device bit set), address bits [31:16] are all zero.
- R5: In a Type 0 address, the function number sits in [10:8] and the register number in [7:2]. Bits [15:11] and [1:0] are zero.
- R6: A request whose bus number is non-zero, greater than secondary and no greater than subordinate yields kind code 2'b10 (Type 1).
- R7: In a Type 1 address, bits [31:24] are zero, the bus number sits in [23:16], the device in [15:11], the function in [10:8] and the register in [7:2]. Bits [1:0] are 01.
- R8: Any other request yields kind code 2'b00 and an all-zero address.
- R9: The result appears with `dn_valid` high one clock after a request is accepted. It holds stable until a clock edge with `dn_ready` high, which clears `dn_valid`.
- R10: `req_ready` is low while a result waits for `dn_ready`. A request offered then is not accepted.
- R11: A write with `bus_wr_sel` = 0 loads the secondary bus number, and a write with `bus_wr_sel` = 1 loads the subordinate bus number.
- R12: `dn_write` carries the `req_write` flag of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Bus-number register write strobe |
| bus_wr_sel | input | 1 | 0 selects secondary, 1 selects subordinate |
| bus_wr_data | input | 8 | Value written to the selected register |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bus | input | 8 | Bus number of the request |
| req_dev | input | 5 | Device number of the request |
| req_func | input | 3 | Function number of the request |
| req_reg | input | 6 | Dword register number of the request |
| req_write | input | 1 | 1 for a configuration write |
| dn_valid | output | 1 | Translated result present |
| dn_ready | input | 1 | Downstream takes the result |
| dn_addr | output | 32 | Translated downstream address |
| dn_kind | output | 2 | 00 none, 01 Type 0, 10 Type 1 |
| dn_write | output | 1 | Write flag of the result |

## Verification
The bench builds the block with its default field widths: 8-bit bus, 5-bit device, 3-bit function, 6-bit register and 32-bit address. At these widths the device select field is exactly sixteen lines wide. A sweep over all 32 device numbers therefore reaches both the one-hot range and the suppressed upper half. The bench also moves the secondary and subordinate numbers, including to zero, to reach the edges of the routing range. These edges are bus equal to secondary, bus one above secondary, bus equal to subordinate, bus one above subordinate, and bus 0 with secondary at 0.

// File: rtl/cfg_xlate_pkg.sv
// Package: shared cycle-kind encoding for the configuration translator.
// Assumes the downstream side decodes the two-bit code as listed here.
package cfg_xlate_pkg;
    typedef enum logic [1:0] {
        CYC_NONE = 2'b00,
        CYC_T0   = 2'b01,
        CYC_T1   = 2'b10
    } cyc_kind_e;
endpackage

// File: rtl/cfg_bus_regs.sv
// Module: holds the secondary and subordinate bus numbers.
// Assumes a single write port; sel 0 targets secondary, sel 1 subordinate.
module cfg_bus_regs #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] sec_bus,
    output logic [BUS_W-1:0] sub_bus
);
    // Load the selected bus-number register; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_bus <= '0;
            sub_bus <= '0;
        end else if (wr_en) begin
            if (wr_sel) sub_bus <= wr_data;
            else        sec_bus <= wr_data;
        end
    end

    AST_REGS_RESET: assert property (@(posedge clk)
        $past(!rst_n) |-> (sec_bus == '0 && sub_bus == '0)); // R1
    AST_SEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (sec_bus == $past(wr_data))); // R11
    AST_SUB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (sub_bus == $past(wr_data))); // R11
endmodule

// File: rtl/cfg_route_dec.sv
// Module: classifies a request by its bus number against the bridge range.
// Assumes that Type 0 takes priority when the bus equals secondary.
module cfg_route_dec
    import cfg_xlate_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output cyc_kind_e        kind
);
    logic hit_local;
    logic hit_below;

    // Compare the bus number with the secondary and subordinate limits.
    always_comb begin
        hit_local = (bus == sec_bus);
        hit_below = (bus != '0) && (bus > sec_bus) && (bus <= sub_bus);
    end

    // Pick the cycle kind with Type 0 first.
    always_comb begin
        if (hit_local)      kind = CYC_T0;
        else if (hit_below) kind = CYC_T1;
        else                kind = CYC_NONE;
    end
endmodule

// File: rtl/cfg_addr_fmt.sv
// Module: builds the downstream address for a given cycle kind.
// Assumes field positions are packed upward from a two-bit type field.
module cfg_addr_fmt
    import cfg_xlate_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FUNC_W = 3,
    parameter int REG_W  = 6,
    parameter int ADDR_W = 32
) (
    input  cyc_kind_e         kind,
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FUNC_W-1:0] func,
    input  logic [REG_W-1:0]  regn,
    output logic [ADDR_W-1:0] addr
);
    localparam int REG_LSB  = 2;
    localparam int FUNC_LSB = REG_LSB + REG_W;
    localparam int DEV_LSB  = FUNC_LSB + FUNC_W;
    localparam int BUS_LSB  = DEV_LSB + DEV_W;
    localparam int SEL_N    = ADDR_W - BUS_LSB;

    logic [SEL_N-1:0] idsel;

    // One select line per device number that fits in the upper field.
    for (genvar g = 0; g < SEL_N; g++) begin : g_sel
        assign idsel[g] = (dev == DEV_W'(g));
    end

    // Place fields according to the selected kind.
    always_comb begin
        addr = '0;
        case (kind)
            CYC_T0: begin
                addr[BUS_LSB +: SEL_N]   = idsel;
                addr[FUNC_LSB +: FUNC_W] = func;
                addr[REG_LSB +: REG_W]   = regn;
                addr[1:0]                = 2'b00;
            end
            CYC_T1: begin
                addr[BUS_LSB +: BUS_W]   = bus;
                addr[DEV_LSB +: DEV_W]   = dev;
                addr[FUNC_LSB +: FUNC_W] = func;
                addr[REG_LSB +: REG_W]   = regn;
                addr[1:0]                = 2'b01;
            end
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/cfg_cycle_xlate.sv
// Module: top of the configuration translator. Takes one request at a time,
// registers the translated address and kind, and holds them until taken.
// Assumes the host keeps a request stable while req_valid is high.
module cfg_cycle_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FUNC_W = 3,
    parameter int REG_W  = 6,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_wr_sel,
    input  logic [BUS_W-1:0]  bus_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              req_write,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [1:0]        dn_kind,
    output logic              dn_write
);
    localparam int SEL_LSB = 2 + REG_W + FUNC_W + DEV_W;

    logic [BUS_W-1:0]  sec_bus;
    logic [BUS_W-1:0]  sub_bus;
    cyc_kind_e         kind_d;
    logic [ADDR_W-1:0] addr_d;
    cyc_kind_e         kind_q;
    logic              take;

    cfg_bus_regs #(.BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .wr_sel(bus_wr_sel),
        .wr_data(bus_wr_data), .sec_bus(sec_bus), .sub_bus(sub_bus)
    );

    cfg_route_dec #(.BUS_W(BUS_W)) u_route (
        .bus(req_bus), .sec_bus(sec_bus), .sub_bus(sub_bus), .kind(kind_d)
    );

    cfg_addr_fmt #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W),
        .REG_W(REG_W), .ADDR_W(ADDR_W)
    ) u_fmt (
        .kind(kind_d), .bus(req_bus), .dev(req_dev), .func(req_func),
        .regn(req_reg), .addr(addr_d)
    );

    // Accept only when no result is waiting.
    always_comb begin
        req_ready = !dn_valid;
        take      = req_valid && req_ready;
    end

    // Output register: load on accept, clear valid when downstream takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_addr  <= '0;
            kind_q   <= CYC_NONE;
            dn_write <= 1'b0;
        end else if (take) begin
            dn_valid <= 1'b1;
            dn_addr  <= addr_d;
            kind_q   <= kind_d;
            dn_write <= req_write;
        end else if (dn_ready) begin
            dn_valid <= 1'b0;
        end
    end

    assign dn_kind = kind_q;

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(!rst_n) |-> !dn_valid); // R1
    AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> dn_valid); // R9
    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_kind) && $stable(dn_write))); // R9
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !req_ready); // R10
    AST_T0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_kind == 2'b01) |-> $onehot0(dn_addr[ADDR_W-1:SEL_LSB])); // R3
    AST_T0_LOWBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_kind == 2'b01) |-> (dn_addr[1:0] == 2'b00)); // R5
    AST_T1_LOWBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_kind == 2'b10) |-> (dn_addr[1:0] == 2'b01)); // R7
    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_kind == 2'b00) |-> (dn_addr == '0)); // R8
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> (dn_kind != 2'b11)); // R2
endmodule

// File: tb/cfg_cycle_xlate_bench.sv
// Bench: directed scenarios, one task each, checking the translator's ports.
module cfg_cycle_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_wr_sel = 1'b0;
    logic [7:0]  bus_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [5:0]  req_reg = '0;
    logic        req_write = 1'b0;
    logic        dn_valid;
    logic        dn_ready = 1'b0;
    logic [31:0] dn_addr;
    logic [1:0]  dn_kind;
    logic        dn_write;

    int vectors = 0;
    int misses  = 0;
    int sec_m   = 0;
    int sub_m   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    cfg_cycle_xlate u_cfg_cycle_xlate (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_sel(bus_wr_sel),
        .bus_wr_data(bus_wr_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_reg(req_reg), .req_write(req_write), .dn_valid(dn_valid),
        .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_kind(dn_kind),
        .dn_write(dn_write)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected kind from the routing rules (R2, R6, R8).
    function automatic logic [1:0] model_kind(input int bus);
        if (bus == sec_m) return 2'b01;
        if (bus != 0 && bus > sec_m && bus <= sub_m) return 2'b10;
        return 2'b00;
    endfunction

    // Expected address from the field layouts (R3, R4, R5, R7).
    function automatic logic [31:0] model_addr(input logic [1:0] k, input int bus,
                                               input int dev, input int fn, input int rg);
        logic [31:0] a = '0;
        if (k == 2'b01) begin
            if (dev < 16) a[16 + dev] = 1'b1;
            a[10:8] = 3'(fn);
            a[7:2]  = 6'(rg);
        end else if (k == 2'b10) begin
            a[23:16] = 8'(bus);
            a[15:11] = 5'(dev);
            a[10:8]  = 3'(fn);
            a[7:2]   = 6'(rg);
            a[1:0]   = 2'b01;
        end
        return a;
    endfunction

    task automatic set_bus(input bit sel, input int val);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_wr_sel = sel; bus_wr_data = 8'(val);
        @(negedge clk);
        bus_wr_en = 1'b0;
        if (sel) sub_m = val; else sec_m = val;
    endtask

    // Offer one request, check the result one clock later, then release it.
    task automatic send(input string tag, input int bus, input int dev,
                        input int fn, input int rg, input bit wr);
        logic [1:0] k = model_kind(bus);
        @(negedge clk);
        check({tag, " R10 ready idle"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_bus = 8'(bus); req_dev = 5'(dev);
        req_func = 3'(fn); req_reg = 6'(rg); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R9 valid"}, 32'(dn_valid), 32'd1);
        check({tag, " kind"}, 32'(dn_kind), 32'(k));
        check({tag, " addr"}, dn_addr, model_addr(k, bus, dev, fn, rg));
        check({tag, " R12 write"}, 32'(dn_write), 32'(wr));
        dn_ready = 1'b1;
        @(negedge clk);
        dn_ready = 1'b0;
        check({tag, " R9 cleared"}, 32'(dn_valid), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 dn_valid", 32'(dn_valid), 32'd0);
        check("R1 req_ready", 32'(req_ready), 32'd1);
        send("R1 R2 bus0 at reset", 0, 3, 1, 5, 1'b0);
    endtask

    task automatic t_dev_sweep;
        for (int d = 0; d < 32; d++)
            send(d < 16 ? "R3 R5 type0 dev" : "R4 type0 high dev", sec_m, d, d % 8, 63 - d, d[0]);
    endtask

    task automatic t_range;
        send("R2 bus=sec", sec_m, 7, 2, 9, 1'b1);
        send("R6 R7 bus=sec+1", sec_m + 1, 9, 6, 33, 1'b0);
        send("R6 R7 bus=sub", sub_m, 31, 7, 63, 1'b1);
        send("R8 bus=sub+1", sub_m + 1, 4, 1, 1, 1'b1);
        send("R8 bus below sec", sec_m - 1, 4, 1, 1, 1'b0);
        send("R8 bus0", 0, 2, 3, 4, 1'b0);
    endtask

    task automatic t_zero_sec;
        set_bus(1'b0, 0);
        set_bus(1'b1, 4);
        send("R2 sec0 bus0", 0, 15, 0, 0, 1'b0);
        send("R6 sec0 bus3", 3, 1, 2, 3, 1'b1);
        send("R8 sec0 bus5", 5, 1, 2, 3, 1'b1);
    endtask

    task automatic t_hold;
        logic [31:0] a0;
        @(negedge clk);
        req_valid = 1'b1; req_bus = 8'(sec_m); req_dev = 5'd2;
        req_func = 3'd1; req_reg = 6'd7; req_write = 1'b1;
        @(negedge clk);
        a0 = dn_addr;
        req_bus = 8'(sub_m); req_dev = 5'd9; req_write = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 hold valid", 32'(dn_valid), 32'd1);
        check("R9 hold addr", dn_addr, a0);
        check("R10 busy ready", 32'(req_ready), 32'd0);
        check("R10 second req not taken", 32'(dn_write), 32'd1);
        dn_ready = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        dn_ready = 1'b0;
        check("R10 no stale accept", 32'(dn_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        set_bus(1'b0, 2);
        set_bus(1'b1, 5);
        t_dev_sweep();
        t_range();
        t_hold();
        t_zero_sec();
        // R11 checked through the routing it changes
        set_bus(1'b1, 9);
        send("R11 sub moved to 9", 9, 0, 0, 0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                misses++;
                vectors++;
                $display("FAIL watchdog R9 actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule